// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write an external asynchronous static RAM of 1M words by 8 bits. On the host side there is a request/acknowledge port. The host raises a request with an address, a direction flag and, for writes, a data byte. It holds the request until a one-cycle acknowledge comes back. For reads, the returned byte is valid in the same cycle as the acknowledge. A separate sleep input moves the memory into its low-power retention state.

On the memory side the controller drives these pins:
- an address bus;
- two chip selects of opposite polarity;
- an active-low write enable;
- an active-low output enable;
- a split data path (output value, output enable, input value) that a pad cell joins into one shared tristate bus.

Every analog timing minimum is a nanosecond parameter. The controller converts each one to a whole number of clock cycles by rounding up against the clock period parameter. All memory pins are registered, so no pin glitches between clock edges.

The write window is the time during which both selects are active and write enable is low. It is opened and closed by write enable alone, with the address, selects and data already settled. Write data is driven from the start of the access until the window closes. After a read, the controller holds its bus driver off for the bus-release time before any write may drive the bus. Retention is entered by pulling the active-high select low. On exit, the memory sits selected-ready but idle for one read-cycle time before the next access.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset the pins are at rest: active-low select high, active-high select high, write enable high, output enable high, data driver off, and acknowledge low.
- R2: A write selects the chip and drives the address and data first. It then holds write enable low for at least ceil(T_WP_NS/CLK_PERIOD_NS) cycles. The address, the data and both selects are held constant while write enable is low. The byte on the data output is the byte stored at that address.
- R3: A read holds both selects active and output enable low for ceil(T_RC_NS/CLK_PERIOD_NS) cycles, with write enable high throughout. It captures the data input on the last clock of that interval and returns it on the read data port. Output enable and write enable are never low together.
- R4: The acknowledge is high for exactly one cycle per request. Latency is counted from the clock edge that accepts the request to the cycle in which the acknowledge is high. For a write it is 1 + NWS + NWP + NWR cycles, where NWP = ceil(T_WP/P), NWS = max(1, max(ceil(T_AW/P), ceil(T_DW/P)) - NWP) and NWR = max(1, ceil(T_WC/P) - NWS - NWP). For a read it is 1 + ceil(T_RC/P) cycles.
- R5: The data driver is on only while write data is presented. It is never on while output enable is low. It is never on within ceil(T_HZ_NS/CLK_PERIOD_NS) cycles after output enable rises, so the controller never drives against the memory.
- R6: While idle, a high sleep input drives the active-high select low and keeps the active-low select, write enable and output enable high, with the driver off. A host request made during sleep is neither performed nor acknowledged.
- R7: When the sleep input falls, the active-high select returns high. No access begins until at least ceil(T_RC_NS/CLK_PERIOD_NS) cycles later.
- R8: If a sleep input and a host request are both present in an idle cycle, the sleep input wins. A sleep input raised while an access is in flight does not cut that access short, and the access still completes and is acknowledged with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write data |
| host_sleep | input | 1 | Request retention sleep |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W | Read data, valid with acknowledge |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select (low = retention) |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_oe | output | 1 | Data pad output enable |
| mem_dq_in | input | DATA_W | Data from the memory |

## Verification
The assertions assume that the host keeps its request, direction, address and data steady from the moment it raises the request until it sees the acknowledge. They also assume that the memory data input matters only in the capture cycle of a read. The stimulus respects this by changing host inputs only on falling clock edges and by dropping the request on the falling edge at which the acknowledge is seen. A timed memory model in the bench presents a decoy byte until the access and output-enable times have elapsed, so a read sampled too early returns wrong data instead of silently passing. The sleep tests raise the sleep input only on falling edges, either alone, together with a request, or one cycle after a request has been accepted.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_SAMPLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURN,
    ST_SLEEP,
    ST_WAKE
  } ctrl_state_e;

  // Round a nanosecond minimum up to whole clock cycles.
  function automatic int ns_to_cyc(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_dly_cnt.sv
`timescale 1ns/1ps
module sram_dly_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int N_RC  = 6,
  parameter int N_WS  = 1,
  parameter int N_WP  = 4,
  parameter int N_WR  = 1,
  parameter int N_HZ  = 2,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_write,
  input  logic             sleep_req,
  input  logic             cnt_zero,
  output ctrl_state_e      state_q,
  output ctrl_state_e      state_d,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             accept
);

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    accept   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sleep_req) begin
          state_d = ST_SLEEP;
        end else if (req) begin
          accept   = 1'b1;
          cnt_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SETUP;
            cnt_val = CNT_W'(N_WS - 1);
          end else begin
            state_d = ST_RD_SETUP;
            cnt_val = CNT_W'(N_RC - 2);
          end
        end
      end
      ST_RD_SETUP: if (cnt_zero) state_d = ST_RD_SAMPLE;
      ST_RD_SAMPLE: begin
        state_d  = ST_TURN;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(N_HZ - 1);
      end
      ST_TURN: if (cnt_zero) state_d = ST_IDLE;
      ST_WR_SETUP: begin
        if (cnt_zero) begin
          state_d  = ST_WR_PULSE;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(N_WP - 1);
        end
      end
      ST_WR_PULSE: begin
        if (cnt_zero) begin
          state_d  = ST_WR_RECOVER;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(N_WR - 1);
        end
      end
      ST_WR_RECOVER: if (cnt_zero) state_d = ST_IDLE;
      ST_SLEEP: begin
        if (!sleep_req) begin
          state_d  = ST_WAKE;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(N_RC - 1);
        end
      end
      ST_WAKE: if (cnt_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/sram_pin_drv.sv
`timescale 1ns/1ps
module sram_pin_drv
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_state_e       state_q,
  input  ctrl_state_e       state_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              ack
);

  logic in_access, in_read, cs_n_d, cs_d, we_n_d, oe_n_d, dq_oe_d, ack_d, cap_en;

  // Pins are a registered function of the next state: glitch-free edges.
  always_comb begin
    in_read   = (state_d == ST_RD_SETUP) || (state_d == ST_RD_SAMPLE);
    in_access = in_read || (state_d == ST_WR_SETUP) ||
                (state_d == ST_WR_PULSE) || (state_d == ST_WR_RECOVER);
    cs_n_d    = !in_access;
    cs_d      = (state_d != ST_SLEEP);
    we_n_d    = (state_d != ST_WR_PULSE);
    oe_n_d    = !in_read;
    dq_oe_d   = (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE);
    cap_en    = (state_q == ST_RD_SAMPLE);
    ack_d     = cap_en || ((state_q == ST_WR_RECOVER) && (state_d == ST_IDLE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_cs    <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      ack       <= 1'b0;
    end else begin
      mem_cs_n  <= cs_n_d;
      mem_cs    <= cs_d;
      mem_we_n  <= we_n_d;
      mem_oe_n  <= oe_n_d;
      mem_dq_oe <= dq_oe_d;
      ack       <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (cap_en) begin
      rdata <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 20,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 55,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 40,
  parameter int T_AW_NS       = 50,
  parameter int T_DW_NS       = 25,
  parameter int T_HZ_NS       = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_sleep,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int N_RC  = max2(2, ns_to_cyc(T_RC_NS, CLK_PERIOD_NS));
  localparam int N_WP  = max2(1, ns_to_cyc(T_WP_NS, CLK_PERIOD_NS));
  localparam int N_AW  = ns_to_cyc(T_AW_NS, CLK_PERIOD_NS);
  localparam int N_DW  = ns_to_cyc(T_DW_NS, CLK_PERIOD_NS);
  localparam int N_WC  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int N_HZ  = max2(1, ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS));
  localparam int N_WS  = max2(1, max2(N_AW, N_DW) - N_WP);
  localparam int N_WR  = max2(1, N_WC - N_WS - N_WP);
  localparam int N_MAX = max2(max2(N_RC, N_WP), max2(max2(N_WS, N_WR), N_HZ));
  localparam int CNT_W = $clog2(N_MAX + 1);

  ctrl_state_e      state_q, state_d;
  logic             cnt_load, cnt_zero, accept;
  logic [CNT_W-1:0] cnt_val;

  sram_seq_fsm #(
    .N_RC(N_RC), .N_WS(N_WS), .N_WP(N_WP), .N_WR(N_WR), .N_HZ(N_HZ), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req(host_req), .req_write(host_write),
    .sleep_req(host_sleep), .cnt_zero(cnt_zero), .state_q(state_q),
    .state_d(state_d), .cnt_load(cnt_load), .cnt_val(cnt_val), .accept(accept)
  );

  sram_dly_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  sram_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .state_d(state_d),
    .accept(accept), .req_addr(host_addr), .req_wdata(host_wdata),
    .mem_dq_in(mem_dq_in), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .rdata(host_rdata),
    .ack(host_ack)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int N_WP   = 4,
  parameter int N_RC   = 6,
  parameter int N_HZ   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic              host_ack
);

  logic [7:0] wp_cnt, hz_cnt, wk_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_cnt <= '0;
      hz_cnt <= 8'hFF;
      wk_cnt <= 8'hFF;
    end else begin
      wp_cnt <= mem_we_n ? 8'd0 : ((wp_cnt == 8'hFF) ? wp_cnt : wp_cnt + 8'd1);
      hz_cnt <= !mem_oe_n ? 8'd0 : ((hz_cnt == 8'hFF) ? hz_cnt : hz_cnt + 8'd1);
      wk_cnt <= !mem_cs ? 8'd0 : ((wk_cnt == 8'hFF) ? wk_cnt : wk_cnt + 8'd1);
    end
  end

  // R2
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wp_cnt >= 8'(N_WP)));

  // R2
  wr_window_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (mem_dq_oe && !mem_cs_n && mem_cs));

  // R2
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> $stable(mem_addr));

  // R3
  oe_we_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n || mem_we_n);

  // R4
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  // R5
  drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R5
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (hz_cnt >= 8'(N_HZ)));

  // R6
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R7
  wake_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (wk_cnt >= 8'(N_RC)));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W(ADDR_W), .N_WP(N_WP), .N_RC(N_RC), .N_HZ(N_HZ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
  .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe), .host_ack(host_ack)
);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

  localparam int P    = 10;
  localparam int NWP  = (40 + P - 1) / P;
  localparam int NAW  = (50 + P - 1) / P;
  localparam int NDW  = (25 + P - 1) / P;
  localparam int NWC  = (55 + P - 1) / P;
  localparam int NRC  = (55 + P - 1) / P;
  localparam int NWS0 = ((NAW > NDW) ? NAW : NDW) - NWP;
  localparam int NWS  = (NWS0 > 1) ? NWS0 : 1;
  localparam int NWR0 = NWC - NWS - NWP;
  localparam int NWR  = (NWR0 > 1) ? NWR0 : 1;
  localparam int EXP_WR = 1 + NWS + NWP + NWR;
  localparam int EXP_RD = 1 + NRC;

  logic        clk, rst_n;
  logic        host_req, host_write, host_sleep;
  logic [19:0] host_addr;
  logic [7:0]  host_wdata;
  logic        host_ack;
  logic [7:0]  host_rdata;
  logic [19:0] m_addr;
  logic        m_cs_n, m_cs, m_we_n, m_oe_n, m_dq_oe;
  logic [7:0]  m_dq_out, m_dq_in;

  int n_checks = 0;
  int n_fail   = 0;
  int wr_viol  = 0;
  int cont_cnt = 0;
  int wake_viol = 0;
  bit finished = 0;

  sram_async_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_write(host_write),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_sleep(host_sleep),
    .host_ack(host_ack), .host_rdata(host_rdata), .mem_addr(m_addr),
    .mem_cs_n(m_cs_n), .mem_cs(m_cs), .mem_we_n(m_we_n), .mem_oe_n(m_oe_n),
    .mem_dq_out(m_dq_out), .mem_dq_oe(m_dq_oe), .mem_dq_in(m_dq_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- timed memory model ----------------
  logic [7:0] mem_arr [0:255];
  realtime t_sel = 0, t_oe_fall = 0, t_oe_rise = 0, t_we_fall = 0;
  realtime t_data = 0, t_cs_rise = 0;

  always @(m_addr or m_cs_n or m_cs) t_sel = $realtime;
  always @(negedge m_oe_n) t_oe_fall = $realtime;
  always @(posedge m_oe_n) t_oe_rise = $realtime;
  always @(negedge m_we_n) t_we_fall = $realtime;
  always @(m_dq_out or posedge m_dq_oe) t_data = $realtime;
  always @(posedge m_cs) t_cs_rise = $realtime;

  always @(negedge m_cs_n) begin
    if ($realtime > 1.0 && ($realtime - t_cs_rise) < 55.0) wake_viol++;
  end

  always @(posedge m_we_n) begin
    if (m_cs_n === 1'b0 && m_cs === 1'b1) begin
      if (($realtime - t_we_fall) < 40.0) wr_viol++;
      if (($realtime - t_data) < 25.0) wr_viol++;
      if (t_sel > t_we_fall) wr_viol++;
      mem_arr[m_addr[7:0]] = m_dq_out;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_arr[i] = 8'h11;
    m_dq_in = 8'hEE;
    #0.5;
    forever begin
      logic rd;
      rd = (m_cs_n === 1'b0) && (m_cs === 1'b1) && (m_we_n === 1'b1) && (m_oe_n === 1'b0);
      if (rd && ($realtime - t_sel >= 55.0) && ($realtime - t_oe_fall >= 35.0))
        m_dq_in = mem_arr[m_addr[7:0]];
      else
        m_dq_in = 8'hEE;
      if (m_dq_oe === 1'b1 && (rd || ($realtime - t_oe_rise < 20.0))) cont_cnt++;
      #1;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input logic [19:0] a, input logic [7:0] d,
                        output logic [7:0] rd, output int lat);
    bit addr_ok = 1;
    @(negedge clk);
    host_req = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
    lat = 0;
    while (lat < 100) begin
      @(negedge clk);
      lat++;
      if (m_we_n === 1'b0 && m_addr !== a) addr_ok = 0;
      if (host_ack) break;
    end
    rd = host_rdata;
    host_req = 1'b0;
    if (wr) check(addr_ok, "R2 address pins during write window", 0, 1);
    @(negedge clk);
    check(host_ack == 1'b0, "R4 acknowledge lasts one cycle", host_ack, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; host_req = 0; host_write = 0; host_sleep = 0;
    host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    check(m_cs_n == 1 && m_cs == 1 && m_we_n == 1 && m_oe_n == 1 && m_dq_oe == 0 && host_ack == 0,
          "R1 idle pins in reset", {m_cs_n, m_cs, m_we_n, m_oe_n, m_dq_oe, host_ack}, 6'b111100);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(m_cs_n == 1 && m_cs == 1 && m_we_n == 1 && m_oe_n == 1 && m_dq_oe == 0,
          "R1 idle pins after reset", {m_cs_n, m_cs, m_we_n, m_oe_n, m_dq_oe}, 5'b11110);
  endtask

  task automatic t_patterns();
    logic [19:0] addrs [4] = '{20'h00001, 20'hFFFFF, 20'h80010, 20'h12345};
    logic [7:0]  datas [4] = '{8'hA5, 8'h5A, 8'h3C, 8'h00};
    logic [7:0] rd;
    int lat;
    for (int i = 0; i < 4; i++) begin
      do_req(1'b1, addrs[i], datas[i], rd, lat);
      check(lat == EXP_WR, "R4 write latency", lat, EXP_WR);
      check(mem_arr[addrs[i][7:0]] == datas[i], "R2 byte stored in memory",
            mem_arr[addrs[i][7:0]], datas[i]);
    end
    for (int i = 3; i >= 0; i--) begin
      do_req(1'b0, addrs[i], 8'h00, rd, lat);
      check(lat == EXP_RD, "R4 read latency", lat, EXP_RD);
      check(rd == datas[i], "R3 read data", rd, datas[i]);
    end
  endtask

  task automatic t_back_to_back();
    logic [7:0] rd;
    int lat;
    do_req(1'b0, 20'h00001, 8'h00, rd, lat);
    check(rd == 8'hA5, "R3 read before write", rd, 8'hA5);
    do_req(1'b1, 20'h00001, 8'hC3, rd, lat);
    do_req(1'b0, 20'h00001, 8'h00, rd, lat);
    check(rd == 8'hC3, "R3 read after overwrite", rd, 8'hC3);
    check(cont_cnt == 0, "R5 no bus contention", cont_cnt, 0);
  endtask

  task automatic t_sleep();
    bit got_ack = 0;
    int n = 0;
    @(negedge clk);
    host_sleep = 1'b1;
    repeat (3) @(negedge clk);
    check(m_cs == 0 && m_cs_n == 1, "R6 retention pins", {m_cs, m_cs_n}, 2'b01);
    host_req = 1'b1; host_write = 1'b0; host_addr = 20'hFFFFF;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (host_ack || m_cs_n == 1'b0) got_ack = 1;
    end
    check(!got_ack, "R6 request ignored while asleep", got_ack, 0);
    host_sleep = 1'b0;
    while (n < 100) begin
      @(negedge clk);
      n++;
      if (host_ack) break;
    end
    host_req = 1'b0;
    check(host_rdata == 8'h5A, "R7 access after wake", host_rdata, 8'h5A);
    check(n >= NRC + 1 + EXP_RD, "R7 wake recovery before access", n, NRC + 1 + EXP_RD);
    check(wake_viol == 0, "R7 select-to-access time after wake", wake_viol, 0);
  endtask

  task automatic t_priority();
    bit saw_ack = 0, cs_low = 0;
    logic [7:0] rd;
    int lat;
    @(negedge clk);
    host_sleep = 1'b1; host_req = 1'b1; host_write = 1'b1;
    host_addr = 20'h00010; host_wdata = 8'h77;
    repeat (2) @(negedge clk);
    check(m_cs == 0 && m_cs_n == 1, "R8 sleep wins over request", {m_cs, m_cs_n}, 2'b01);
    host_req = 1'b0; host_sleep = 1'b0;
    check(mem_arr[8'h10] == 8'h3C, "R8 no write while sleep won", mem_arr[8'h10], 8'h3C);
    repeat (NRC + 2) @(negedge clk);
    host_req = 1'b1; host_write = 1'b1; host_addr = 20'h00020; host_wdata = 8'h96;
    @(negedge clk);
    host_sleep = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (host_ack) begin saw_ack = 1; host_req = 1'b0; end
      if (!saw_ack && m_cs == 1'b0) cs_low = 1;
      if (saw_ack) break;
    end
    check(saw_ack && !cs_low, "R8 access in flight completes", {saw_ack, cs_low}, 2'b10);
    check(mem_arr[8'h20] == 8'h96, "R8 in-flight write stored", mem_arr[8'h20], 8'h96);
    repeat (3) @(negedge clk);
    check(m_cs == 0, "R6 sleep taken after access", m_cs, 0);
    host_sleep = 1'b0;
    do_req(1'b0, 20'h00020, 8'h00, rd, lat);
    check(rd == 8'h96, "R7 read after second wake", rd, 8'h96);
    check(wr_viol == 0, "R2 write window timing", wr_viol, 0);
    check(cont_cnt == 0, "R5 no bus contention overall", cont_cnt, 0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_patterns();
    t_back_to_back();
    t_sleep();
    t_priority();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule